// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line into characters. A 16x oversampling enable marks the sampling instants. The block qualifies the start bit at its centre and then samples each data bit, the optional parity bit and the first stop bit at mid-bit. The character and its error flags appear together on a one-clock valid strobe. The frame format comes from static inputs: a two-bit length code for 5 to 8 data bits, a parity enable, a parity type and a forced-parity select. These inputs follow the same rules the matching transmitter uses, so one setting drives both directions.

The control is a single state machine with these states:
- ST_IDLE: waits for a low line.
- ST_START: counts eight ticks to the start-bit centre. If the line is low there it moves to ST_DATA. If the line is high it returns to ST_IDLE.
- ST_DATA: takes one data bit every sixteen ticks, LSB first. After the last bit it moves to ST_PARITY when parity is enabled, and to ST_STOP when it is not.
- ST_PARITY: samples the parity bit, then moves to ST_STOP.
- ST_STOP: samples the first stop bit, then moves to ST_DELIVER.
- ST_DELIVER: lasts one clock and registers the outputs, then moves to ST_WAIT_HIGH.
- ST_WAIT_HIGH: holds until the line is high again, then returns to ST_IDLE.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, rx_valid, rx_data, err_parity, err_frame and brk_det are all zero.
- R2: len_sel codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits are received LSB first and placed from bit 0 of rx_data upward. Unused upper bits of rx_data read zero.
- R3: A parity bit is expected only when par_en is 1. When par_en is 0, the bit after the last data bit is taken as the stop bit, and err_parity stays 0.
- R4: When par_force is 0, par_type 0 requires an odd number of ones across the data bits and the parity bit, and par_type 1 requires an even number. A mismatch sets err_parity.
- R5: When par_force is 1, the expected parity bit is 1 for par_type 0 and 0 for par_type 1, whatever the data. A mismatch sets err_parity.
- R6: A low level on the line is accepted as a start bit only if the line is still low at the 8th tick after it was seen. Otherwise the receiver returns to idle and produces no character.
- R7: Only the first stop bit is sampled, and err_frame is set when it reads low. A new start bit may follow directly after one stop bit.
- R8: brk_det is set when every data bit, the parity bit (if enabled) and the stop bit are all zero. In that case err_frame is also set and rx_data is zero.
- R9: rx_valid is high for exactly one clock per character, and rx_data and the flags are valid in that clock. After a character the receiver looks for no new start bit until the line has returned high, so a line held low produces a single character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| len_sel | input | 2 | Data length code (0 to 3 selects 5 to 8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_type | input | 1 | Parity type: 0 odd, 1 even; with forcing, 0 expects 1 and 1 expects 0 |
| par_force | input | 1 | Forced-parity select |
| rx_valid | output | 1 | One-clock strobe for a received character |
| rx_data | output | 8 | Received character, upper bits zero for short words |
| err_parity | output | 1 | Parity mismatch |
| err_frame | output | 1 | First stop bit sampled low |
| brk_det | output | 1 | All-zero frame including the stop bit |

## Verification
The hardest situation to reach is the ST_WAIT_HIGH hold after a break. The stop sample has already been taken, but the line stays low for several more character times. If the receiver wrongly re-armed, it would read that low level as new start bits. The stimulus sends an all-zero frame and holds the line low for five more bit times. It then checks that exactly one strobe arrived, carrying the break and framing flags, and that a normal frame sent next is still received. A sweep over all 32 format settings, sending correct and inverted parity bits, covers every path through the parity and width logic.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_DELIVER,
        ST_WAIT_HIGH
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_width.sv
module uart_rx_width #(
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2,
    localparam int IDX_W    = $clog2(DATA_MAX),
    localparam int MIN_BITS = DATA_MAX - (2**LEN_W - 1)
) (
    input  logic [LEN_W-1:0]    len_sel,
    output logic [IDX_W-1:0]    last_idx,
    output logic [DATA_MAX-1:0] mask
);
    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_sel);

    for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
        assign mask[i] = (IDX_W'(i) <= last_idx);
    end
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int DATA_MAX = 8
) (
    input  logic [DATA_MAX-1:0] data,
    input  logic                par_type,
    input  logic                par_force,
    output logic                exp_bit
);
    logic xor_all;

    assign xor_all = ^data;

    always_comb begin
        if (par_force) exp_bit = ~par_type;
        else           exp_bit = xor_all ^ ~par_type;
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rx_line,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic                par_en,
    input  logic                par_type,
    input  logic                par_force,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                err_parity,
    output logic                err_frame,
    output logic                brk_det
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_MAX);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);

    rx_state_e             state, state_nx;
    logic                  rx_s;
    logic [CNT_W-1:0]      cnt;
    logic [IDX_W-1:0]      bit_idx;
    logic [IDX_W-1:0]      last_idx;
    logic [DATA_MAX-1:0]   mask;
    logic [DATA_MAX-1:0]   shreg;
    logic                  par_bit;
    logic                  stop_bit;
    logic                  exp_par;
    logic                  bit_done;
    logic                  mid_start;

    uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .d_sync  (rx_s)
    );

    uart_rx_width #(.DATA_MAX(DATA_MAX), .LEN_W(LEN_W)) u_width (
        .len_sel  (len_sel),
        .last_idx (last_idx),
        .mask     (mask)
    );

    uart_rx_parity #(.DATA_MAX(DATA_MAX)) u_par (
        .data      (shreg & mask),
        .par_type  (par_type),
        .par_force (par_force),
        .exp_bit   (exp_par)
    );

    assign bit_done  = tick16 && (cnt == LAST_TICK);
    assign mid_start = tick16 && (cnt == MID_TICK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (!rx_s) state_nx = ST_START;
            ST_START:     if (mid_start) state_nx = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:      if (bit_done && bit_idx == last_idx)
                              state_nx = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:    if (bit_done) state_nx = ST_STOP;
            ST_STOP:      if (bit_done) state_nx = ST_DELIVER;
            ST_DELIVER:   state_nx = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (rx_s) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Sampling datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            stop_bit   <= 1'b1;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            brk_det    <= 1'b0;
        end else begin
            if (state != state_nx)      cnt <= '0;
            else if (tick16)            cnt <= (cnt == LAST_TICK) ? '0 : cnt + 1'b1;

            if (state == ST_START && state_nx == ST_DATA) begin
                shreg   <= '0;
                bit_idx <= '0;
                par_bit <= 1'b0;
            end
            if (state == ST_DATA && bit_done) begin
                shreg[bit_idx] <= rx_s;
                bit_idx        <= bit_idx + 1'b1;
            end
            if (state == ST_PARITY && bit_done) par_bit  <= rx_s;
            if (state == ST_STOP   && bit_done) stop_bit <= rx_s;

            rx_valid <= (state == ST_DELIVER);
            if (state == ST_DELIVER) begin
                rx_data    <= shreg & mask;
                err_parity <= par_en && (par_bit != exp_par);
                err_frame  <= !stop_bit;
                brk_det    <= ((shreg & mask) == '0) && !par_bit && !stop_bit;
            end
        end
    end
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2,
    localparam int MIN_BITS = DATA_MAX - (2**LEN_W - 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic [DATA_MAX-1:0] rx_data,
    input logic [LEN_W-1:0]    len_sel,
    input logic                par_en,
    input logic                err_parity,
    input logic                err_frame,
    input logic                brk_det
);
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_break_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && brk_det) |-> err_frame);

    assert_break_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && brk_det) |-> (rx_data == '0));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (MIN_BITS + int'(len_sel))) == '0));

    assert_no_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |-> !err_parity);
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DATA_MAX(DATA_MAX), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .len_sel    (len_sel),
    .par_en     (par_en),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .brk_det    (brk_det)
);

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICKDIV    = 2;
    localparam int BITCLK     = 16 * TICKDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0, par_type = 1'b0, par_force = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       err_parity, err_frame, brk_det;

    int tests = 0;
    int fails = 0;
    int nvalid = 0;
    logic [7:0] cap_d;
    logic cap_pe, cap_fe, cap_bk;
    bit done = 0;

    uart_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .len_sel(len_sel), .par_en(par_en), .par_type(par_type), .par_force(par_force),
        .rx_valid(rx_valid), .rx_data(rx_data), .err_parity(err_parity),
        .err_frame(err_frame), .brk_det(brk_det)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv   <= (tdiv == TICKDIV - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICKDIV - 1);
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            nvalid <= nvalid + 1;
            cap_d  <= rx_data;
            cap_pe <= err_parity;
            cap_fe <= err_frame;
            cap_bk <= brk_det;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input string act, input string exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int n, input bit pen,
                              input bit pbit, input bit stopv);
        rx_line = 1'b0; wait_bits(1);
        for (int i = 0; i < n; i++) begin rx_line = d[i]; wait_bits(1); end
        if (pen) begin rx_line = pbit; wait_bits(1); end
        rx_line = stopv; wait_bits(1);
        rx_line = 1'b1;
    endtask

    function automatic bit exp_par(input logic [7:0] d, input bit pt, input bit pf);
        if (pf) return !pt;
        return pt ? ^d : ~^d;
    endfunction

    task automatic expect_char(input int n0, input logic [7:0] ed, input bit epe,
                               input bit efe, input bit ebk, input string req);
        check(nvalid == n0 + 1, req, $sformatf("count=%0d", nvalid - n0), "count=1");
        check({cap_d, cap_pe, cap_fe, cap_bk} == {ed, epe, efe, ebk}, req,
              $sformatf("d=%02h pe=%0b fe=%0b bk=%0b", cap_d, cap_pe, cap_fe, cap_bk),
              $sformatf("d=%02h pe=%0b fe=%0b bk=%0b", ed, epe, efe, ebk));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] vals [3];
        vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hFF;
        repeat (5) @(negedge clk);
        // R1 reset state
        check({rx_valid, rx_data, err_parity, err_frame, brk_det} == 12'd0, "R1",
              $sformatf("%03h", {rx_valid, rx_data, err_parity, err_frame, brk_det}), "000");
        rst_n = 1'b1;
        wait_bits(1);

        // R2 R3 R4 R5: sweep all formats
        for (int ls = 0; ls < 4; ls++)
          for (int pe = 0; pe < 2; pe++)
            for (int pt = 0; pt < 2; pt++)
              for (int pf = 0; pf < 2; pf++) begin
                int n;
                string tag;
                n = 5 + ls;
                len_sel = 2'(ls); par_en = pe[0]; par_type = pt[0]; par_force = pf[0];
                tag = (pe == 0) ? "R2/R3" : ((pf == 1) ? "R2/R5" : "R2/R4");
                for (int v = 0; v < 3; v++) begin
                    logic [7:0] md;
                    int n0;
                    md = vals[v] & 8'((1 << n) - 1);
                    n0 = nvalid;
                    send_frame(vals[v], n, pe[0], exp_par(md, pt[0], pf[0]), 1'b1);
                    wait_bits(2);
                    expect_char(n0, md, 1'b0, 1'b0, 1'b0, tag);
                end
                if (pe == 1) begin
                    logic [7:0] md;
                    int n0;
                    md = 8'h5A & 8'((1 << n) - 1);
                    n0 = nvalid;
                    send_frame(8'h5A, n, 1'b1, !exp_par(md, pt[0], pf[0]), 1'b1);
                    wait_bits(2);
                    expect_char(n0, md, 1'b1, 1'b0, 1'b0, (pf == 1) ? "R5 bad parity" : "R4 bad parity");
                end
              end

        len_sel = 2'd3; par_en = 1'b0; par_type = 1'b0; par_force = 1'b0;

        // R6 glitch shorter than half a bit
        begin
            int n0;
            n0 = nvalid;
            rx_line = 1'b0; repeat (5 * TICKDIV) @(negedge clk);
            rx_line = 1'b1; wait_bits(12);
            check(nvalid == n0, "R6 glitch", $sformatf("count=%0d", nvalid - n0), "count=0");
            n0 = nvalid;
            send_frame(8'h81, 8, 1'b0, 1'b0, 1'b1); wait_bits(2);
            expect_char(n0, 8'h81, 1'b0, 1'b0, 1'b0, "R6 after glitch");
        end

        // R7 low stop bit, then back-to-back frames with one stop bit
        begin
            int n0;
            n0 = nvalid;
            send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0); wait_bits(2);
            expect_char(n0, 8'h42, 1'b0, 1'b1, 1'b0, "R7 low stop");
            n0 = nvalid;
            send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
            send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1); wait_bits(2);
            check(nvalid == n0 + 2, "R7 back-to-back", $sformatf("count=%0d", nvalid - n0), "count=2");
            check(cap_d == 8'hC3 && !cap_fe, "R7 back-to-back",
                  $sformatf("d=%02h fe=%0b", cap_d, cap_fe), "d=c3 fe=0");
        end

        // R8 R9 break held low
        begin
            int n0;
            n0 = nvalid;
            send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0);
            rx_line = 1'b0; wait_bits(5);
            rx_line = 1'b1; wait_bits(2);
            expect_char(n0, 8'h00, 1'b0, 1'b1, 1'b1, "R8/R9 break held low");
            par_en = 1'b1; par_force = 1'b1; par_type = 1'b1;
            n0 = nvalid;
            send_frame(8'h00, 8, 1'b1, 1'b0, 1'b0); wait_bits(2);
            expect_char(n0, 8'h00, 1'b0, 1'b1, 1'b1, "R8 break with parity");
            n0 = nvalid;
            send_frame(8'h00, 8, 1'b1, 1'b1, 1'b0); wait_bits(2);
            expect_char(n0, 8'h00, 1'b1, 1'b1, 1'b0, "R8 parity one no break");
            par_en = 1'b0; par_force = 1'b0; par_type = 1'b0;
            n0 = nvalid;
            send_frame(8'h7E, 8, 1'b0, 1'b0, 1'b1); wait_bits(2);
            expect_char(n0, 8'h7E, 1'b0, 1'b0, 1'b0, "R9 recovery");
        end

        done = 1;
        summary();
    end
endmodule